// File: doc/BRIEF.md
# Planar Graphics Write/Read Datapath

This block sits between a byte-wide CPU port and four byte-wide bit planes that share one address. A CPU read fetches the addressed byte of every plane at once into a hidden 32-bit latch and returns one byte to the CPU. That byte is either the plane picked by a plane-select register or a colour-compare result. A CPU write builds one byte per plane from the rotated CPU byte, the per-plane fill values and the latch. It passes them through a selectable logic unit, merges the result with the latch under a bit mask, and stores it in every plane that the map-mask input enables.

Software reaches the control registers in two steps. It writes a register number to the index register, then reads or writes the data port. Graphics software uses the latch in two main ways. A read followed by a write of any byte paints a fill colour into chosen pixels. A read followed by a write in latch-copy mode moves four planes' worth of data in one access.

Top module: `gfx_planar_ctrl`

## Requirements
- R1: After reset the index register, the latch and `cpu_rdata` are 0, the bit mask register (index 8) reads 0xFF, and every other control register reads 0.
- R2: A register-port write with `reg_is_data`=0 loads `reg_wdata[3:0]` into the index register. With `reg_is_data`=0, `reg_rdata` returns the index. With `reg_is_data`=1, a write updates the register the index names (0 fill value, 1 fill enable, 2 compare colour, 3 rotate/logic, 4 plane select, 5 mode, 8 bit mask) and `reg_rdata` returns that register's value. Unused bits read 0.
- R3: A CPU read loads the latch with all four plane bytes at `cpu_addr`. In read mode 0 (mode register bit 3 = 0), `cpu_rdata` in the following cycle is the byte of the plane given by register 4 bits 1:0.
- R4: In read mode 1, each bit of `cpu_rdata` is 1 exactly where the four plane bits at that position, plane 3 down to plane 0, equal register 2 bits 3:0.
- R5: Register 3 bits 2:0 give a right-rotate count that is applied to the CPU write byte before use.
- R6: Register 3 bits 4:3 pick the logic function applied between the data and the latch byte of each plane: 0 passes the data, 1 is AND, 2 is OR, 3 is XOR.
- R7: In write mode 0 (mode bits 1:0 = 0), for a plane whose fill-enable bit (register 1) is set, the data is 0xFF or 0x00 according to that plane's bit of the fill value (register 0). The CPU byte then has no effect on that plane.
- R8: Where a bit of the bit mask is 0, every plane keeps its latch bit. Where it is 1, the plane takes the logic-unit result.
- R9: Write mode 1 stores each plane's latch byte unchanged, whatever the CPU byte, the bit mask and the logic function.
- R10: Write mode 2 fills plane p with 0xFF or 0x00 from CPU byte bit p, then applies the logic function and the bit mask.
- R11: Write mode 3 uses the fill value bits as per-plane fill data and uses the rotated CPU byte ANDed with the bit mask as the mask.
- R12: A plane is written only if its bit of `map_mask` is 1. Other planes keep their contents.
- R13: `cpu_rdata` and the latch change only in a cycle where `cpu_rd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register-port write strobe |
| reg_is_data | input | 1 | 0 selects the index register, 1 the data port |
| reg_wdata | input | 8 | Register-port write data |
| reg_rdata | output | 8 | Register-port read data (combinational) |
| cpu_rd | input | 1 | CPU plane-memory read strobe |
| cpu_wr | input | 1 | CPU plane-memory write strobe |
| cpu_addr | input | ADDR_W | Plane byte address |
| cpu_wdata | input | 8 | CPU write byte |
| map_mask | input | 4 | Per-plane write enable |
| cpu_rdata | output | 8 | CPU read byte, registered |

## Verification
Register reads are combinational, so the bench checks `reg_rdata` in the same low clock phase in which it sets the index and port select. A CPU read updates the latch and `cpu_rdata` at the clock edge that samples the strobe, so the bench checks them at the following falling edge. A CPU write lands in the planes at its sampling edge, and the bench then checks it through four plane-select reads, each read one edge later. Every stimulus is driven on the falling edge, half a period away from the edge that captures it.

// File: rtl/gfx_pkg.sv
package gfx_pkg;

    localparam int PLANES = 4;
    localparam int BYTE_W = 8;

    localparam logic [3:0] IDX_FILL_VAL = 4'd0;
    localparam logic [3:0] IDX_FILL_EN  = 4'd1;
    localparam logic [3:0] IDX_CMP_COL  = 4'd2;
    localparam logic [3:0] IDX_ROT_OP   = 4'd3;
    localparam logic [3:0] IDX_PLANE    = 4'd4;
    localparam logic [3:0] IDX_MODE     = 4'd5;
    localparam logic [3:0] IDX_BITMASK  = 4'd8;

    typedef enum logic [1:0] {
        LOP_PASS = 2'd0,
        LOP_AND  = 2'd1,
        LOP_OR   = 2'd2,
        LOP_XOR  = 2'd3
    } logic_op_e;

    typedef enum logic [1:0] {
        WM_CPU    = 2'd0,
        WM_LATCH  = 2'd1,
        WM_EXPAND = 2'd2,
        WM_MASKED = 2'd3
    } wmode_e;

    typedef struct packed {
        logic [3:0] fill_val;
        logic [3:0] fill_en;
        logic [3:0] cmp_col;
        logic [2:0] rot;
        logic_op_e  op;
        logic [1:0] rd_plane;
        wmode_e     wmode;
        logic       rmode;
        logic [7:0] bit_mask;
    } gfx_cfg_t;

    typedef logic [PLANES-1:0][BYTE_W-1:0] plane_word_t;

    function automatic logic [7:0] rotr8(input logic [7:0] d, input logic [2:0] n);
        logic [15:0] dbl;
        dbl = {d, d} >> n;
        return dbl[7:0];
    endfunction

    function automatic logic [7:0] apply_op(input logic_op_e op,
                                            input logic [7:0] d,
                                            input logic [7:0] l);
        case (op)
            LOP_AND: return d & l;
            LOP_OR:  return d | l;
            LOP_XOR: return d ^ l;
            default: return d;
        endcase
    endfunction

endpackage

// File: rtl/gfx_regfile.sv
module gfx_regfile
    import gfx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_wr,
    input  logic       reg_is_data,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic [3:0] index_q,
    output gfx_cfg_t   cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            index_q      <= '0;
            cfg          <= '0;
            cfg.bit_mask <= 8'hFF;
        end else if (reg_wr) begin
            if (!reg_is_data) begin
                index_q <= reg_wdata[3:0];
            end else begin
                case (index_q)
                    IDX_FILL_VAL: cfg.fill_val <= reg_wdata[3:0];
                    IDX_FILL_EN:  cfg.fill_en  <= reg_wdata[3:0];
                    IDX_CMP_COL:  cfg.cmp_col  <= reg_wdata[3:0];
                    IDX_ROT_OP: begin
                        cfg.rot <= reg_wdata[2:0];
                        cfg.op  <= logic_op_e'(reg_wdata[4:3]);
                    end
                    IDX_PLANE:    cfg.rd_plane <= reg_wdata[1:0];
                    IDX_MODE: begin
                        cfg.wmode <= wmode_e'(reg_wdata[1:0]);
                        cfg.rmode <= reg_wdata[3];
                    end
                    IDX_BITMASK:  cfg.bit_mask <= reg_wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (!reg_is_data) begin
            reg_rdata = {4'h0, index_q};
        end else begin
            case (index_q)
                IDX_FILL_VAL: reg_rdata = {4'h0, cfg.fill_val};
                IDX_FILL_EN:  reg_rdata = {4'h0, cfg.fill_en};
                IDX_CMP_COL:  reg_rdata = {4'h0, cfg.cmp_col};
                IDX_ROT_OP:   reg_rdata = {3'h0, cfg.op, cfg.rot};
                IDX_PLANE:    reg_rdata = {6'h0, cfg.rd_plane};
                IDX_MODE:     reg_rdata = {4'h0, cfg.rmode, 1'b0, cfg.wmode};
                IDX_BITMASK:  reg_rdata = cfg.bit_mask;
                default:      reg_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/gfx_write_unit.sv
module gfx_write_unit
    import gfx_pkg::*;
(
    input  logic [3:0]  fill_val,
    input  logic [3:0]  fill_en,
    input  logic [2:0]  rot,
    input  logic_op_e   op,
    input  wmode_e      wmode,
    input  logic [7:0]  bit_mask,
    input  logic [7:0]  cpu_wdata,
    input  plane_word_t latch,
    output plane_word_t wr_word
);

    logic [7:0] rot_byte;
    logic [7:0] eff_mask;

    always_comb begin
        rot_byte = rotr8(cpu_wdata, rot);
        eff_mask = (wmode == WM_MASKED) ? (rot_byte & bit_mask) : bit_mask;
    end

    for (genvar p = 0; p < PLANES; p++) begin : g_plane
        logic [7:0] src;
        logic [7:0] alu;
        always_comb begin
            case (wmode)
                WM_EXPAND: src = {8{cpu_wdata[p]}};
                WM_MASKED: src = {8{fill_val[p]}};
                default:   src = fill_en[p] ? {8{fill_val[p]}} : rot_byte;
            endcase
            alu = apply_op(op, src, latch[p]);
            if (wmode == WM_LATCH)
                wr_word[p] = latch[p];
            else
                wr_word[p] = (alu & eff_mask) | (latch[p] & ~eff_mask);
        end
    end

endmodule

// File: rtl/gfx_plane_store.sv
module gfx_plane_store
    import gfx_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [3:0]        we_mask,
    input  plane_word_t       wr_word,
    input  logic [1:0]        rd_plane,
    input  logic              rmode,
    input  logic [3:0]        cmp_col,
    output plane_word_t       latch_q,
    output logic [7:0]        cpu_rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    plane_word_t rd_word;

    for (genvar p = 0; p < PLANES; p++) begin : g_mem
        logic [7:0] mem [DEPTH];
        always_ff @(posedge clk) begin
            if (cpu_wr && we_mask[p])
                mem[cpu_addr] <= wr_word[p];
        end
        assign rd_word[p] = mem[cpu_addr];
    end

    logic [7:0] cmp_hit;

    always_comb begin
        for (int b = 0; b < BYTE_W; b++) begin
            cmp_hit[b] = ({rd_word[3][b], rd_word[2][b], rd_word[1][b], rd_word[0][b]} == cmp_col);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q   <= '0;
            cpu_rdata <= '0;
        end else if (cpu_rd) begin
            latch_q   <= rd_word;
            cpu_rdata <= rmode ? cmp_hit : rd_word[rd_plane];
        end
    end

endmodule

// File: rtl/gfx_planar_ctrl.sv
module gfx_planar_ctrl
    import gfx_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_is_data,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic [3:0]        map_mask,
    output logic [7:0]        cpu_rdata
);

    gfx_cfg_t    cfg;
    logic [3:0]  index_q;
    plane_word_t latch_q;
    plane_word_t wr_word;

    gfx_regfile u_regs (
        .clk        (clk),
        .rst        (rst),
        .reg_wr     (reg_wr),
        .reg_is_data(reg_is_data),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .index_q    (index_q),
        .cfg        (cfg)
    );

    gfx_write_unit u_wr (
        .fill_val (cfg.fill_val),
        .fill_en  (cfg.fill_en),
        .rot      (cfg.rot),
        .op       (cfg.op),
        .wmode    (cfg.wmode),
        .bit_mask (cfg.bit_mask),
        .cpu_wdata(cpu_wdata),
        .latch    (latch_q),
        .wr_word  (wr_word)
    );

    gfx_plane_store #(.ADDR_W(ADDR_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .cpu_rd   (cpu_rd),
        .cpu_wr   (cpu_wr),
        .cpu_addr (cpu_addr),
        .we_mask  (map_mask),
        .wr_word  (wr_word),
        .rd_plane (cfg.rd_plane),
        .rmode    (cfg.rmode),
        .cmp_col  (cfg.cmp_col),
        .latch_q  (latch_q),
        .cpu_rdata(cpu_rdata)
    );

endmodule

// File: rtl/gfx_planar_ctrl_chk.sv
module gfx_planar_ctrl_chk
    import gfx_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        cpu_rd,
    input logic        cpu_wr,
    input logic        reg_wr,
    input logic        reg_is_data,
    input logic [7:0]  reg_wdata,
    input logic [7:0]  cpu_rdata,
    input logic [3:0]  index_q,
    input gfx_cfg_t    cfg,
    input plane_word_t latch_q,
    input plane_word_t wr_word
);

    logic [31:0] keep_bits;
    assign keep_bits = ~{4{cfg.bit_mask}};

    AST_INDEX_LOAD: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !reg_is_data) |=> (index_q == $past(reg_wdata[3:0]))); // R2

    AST_MASK_KEEPS_LATCH: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cfg.wmode != WM_MASKED) |-> (((wr_word ^ latch_q) & keep_bits) == 32'h0)); // R8

    AST_LATCH_COPY: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cfg.wmode == WM_LATCH) |-> (wr_word == latch_q)); // R9

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cpu_rd |=> $stable(cpu_rdata)); // R13

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cpu_rd |=> $stable(latch_q)); // R13

endmodule

bind gfx_planar_ctrl gfx_planar_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cpu_rd     (cpu_rd),
    .cpu_wr     (cpu_wr),
    .reg_wr     (reg_wr),
    .reg_is_data(reg_is_data),
    .reg_wdata  (reg_wdata),
    .cpu_rdata  (cpu_rdata),
    .index_q    (index_q),
    .cfg        (cfg),
    .latch_q    (latch_q),
    .wr_word    (wr_word)
);

// File: tb/gfx_planar_ctrl_tb_top.sv
module gfx_planar_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 8;
    localparam int WATCHDOG   = 50000;

    typedef struct packed {
        logic [1:0]  mode;
        logic [7:0]  rot_op;
        logic [3:0]  fill_en;
        logic [3:0]  fill_val;
        logic [7:0]  mask;
        logic [3:0]  mm;
        logic [7:0]  wdata;
        logic [31:0] expect_planes; // plane3..plane0
    } vec_t;

    localparam int NVEC = 13;
    // Planes preloaded as P0=0F P1=33 P2=55 P3=F0 before each vector.
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 8'h00, 4'h0, 4'h0, 8'hFF, 4'hF, 8'hA5, 32'hA5A5A5A5}, // plain write
        '{2'd0, 8'h04, 4'h0, 4'h0, 8'hFF, 4'hF, 8'h12, 32'h21212121}, // R5 rotate 4
        '{2'd0, 8'h01, 4'h0, 4'h0, 8'hFF, 4'hF, 8'h01, 32'h80808080}, // R5 wrap
        '{2'd0, 8'h08, 4'h0, 4'h0, 8'hFF, 4'hF, 8'h3C, 32'h3014300C}, // R6 AND
        '{2'd0, 8'h10, 4'h0, 4'h0, 8'hFF, 4'hF, 8'h3C, 32'hFC7D3F3F}, // R6 OR
        '{2'd0, 8'h18, 4'h0, 4'h0, 8'hFF, 4'hF, 8'hFF, 32'h0FAACCF0}, // R6 XOR
        '{2'd0, 8'h00, 4'hF, 4'h5, 8'h3C, 4'hF, 8'h00, 32'hC07D033F}, // R7 R8 fill
        '{2'd0, 8'h00, 4'h3, 4'h1, 8'hFF, 4'hF, 8'h66, 32'h666600FF}, // R7 partial
        '{2'd1, 8'h18, 4'h0, 4'h0, 8'h00, 4'hF, 8'h77, 32'hF055330F}, // R9 copy
        '{2'd2, 8'h00, 4'h0, 4'h0, 8'hF0, 4'hF, 8'h09, 32'hF00503FF}, // R10 expand
        '{2'd3, 8'h00, 4'h0, 4'h6, 8'h3C, 4'hF, 8'h0F, 32'hF05D3F03}, // R11
        '{2'd0, 8'h00, 4'h0, 4'h0, 8'hFF, 4'h5, 8'hAA, 32'hF0AA33AA}, // R12
        '{2'd3, 8'h02, 4'h0, 4'hF, 8'hFF, 4'hF, 8'hF0, 32'hFC7D3F3F}  // R11 rotated
    };

    logic              clk = 1'b0;
    logic              rst;
    logic              reg_wr, reg_is_data;
    logic [7:0]        reg_wdata, reg_rdata;
    logic              cpu_rd, cpu_wr;
    logic [ADDR_W-1:0] cpu_addr;
    logic [7:0]        cpu_wdata, cpu_rdata;
    logic [3:0]        map_mask;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gfx_planar_ctrl #(.ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_is_data(reg_is_data),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .map_mask(map_mask), .cpu_rdata(cpu_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_reg(input logic [3:0] idx, input logic [7:0] val);
        reg_wr = 1'b1; reg_is_data = 1'b0; reg_wdata = {4'h0, idx};
        @(negedge clk);
        reg_is_data = 1'b1; reg_wdata = val;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic cpu_write(input logic [ADDR_W-1:0] a, input logic [7:0] d, input logic [3:0] mm);
        cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d; map_mask = mm;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic cpu_read(input logic [ADDR_W-1:0] a, output logic [7:0] d);
        cpu_rd = 1'b1; cpu_addr = a;
        @(negedge clk);
        cpu_rd = 1'b0;
        d = cpu_rdata;
    endtask

    task automatic default_regs();
        set_reg(4'd5, 8'h00);
        set_reg(4'd3, 8'h00);
        set_reg(4'd1, 8'h00);
        set_reg(4'd8, 8'hFF);
    endtask

    task automatic preload(input logic [ADDR_W-1:0] a);
        default_regs();
        cpu_write(a, 8'h0F, 4'h1);
        cpu_write(a, 8'h33, 4'h2);
        cpu_write(a, 8'h55, 4'h4);
        cpu_write(a, 8'hF0, 4'h8);
    endtask

    task automatic read_planes(input logic [ADDR_W-1:0] a, output logic [31:0] w);
        logic [7:0] b;
        set_reg(4'd5, 8'h00);
        for (int p = 0; p < 4; p++) begin
            set_reg(4'd4, p[7:0]);
            cpu_read(a, b);
            w[p*8 +: 8] = b;
        end
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        logic [7:0]  b;
        logic [31:0] w;
        rst = 1'b1; reg_wr = 1'b0; reg_is_data = 1'b0; reg_wdata = '0;
        cpu_rd = 1'b0; cpu_wr = 1'b0; cpu_addr = '0; cpu_wdata = '0; map_mask = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 rdata", {24'h0, cpu_rdata}, 32'h0);
        reg_is_data = 1'b0;
        #1 check("R1 index", {24'h0, reg_rdata}, 32'h0);
        reg_wr = 1'b1; reg_wdata = 8'h08;
        @(negedge clk);
        reg_wr = 1'b0; reg_is_data = 1'b1;
        #1 check("R1 bitmask", {24'h0, reg_rdata}, 32'hFF);
        reg_is_data = 1'b0; reg_wr = 1'b1; reg_wdata = 8'h05;
        @(negedge clk);
        reg_wr = 1'b0; reg_is_data = 1'b1;
        #1 check("R1 mode", {24'h0, reg_rdata}, 32'h0);

        // R2 index readback and data port
        set_reg(4'd2, 8'hFA);
        reg_is_data = 1'b0;
        #1 check("R2 index", {24'h0, reg_rdata}, 32'h02);
        reg_is_data = 1'b1;
        #1 check("R2 data", {24'h0, reg_rdata}, 32'h0A);
        set_reg(4'd3, 8'hFF);
        reg_is_data = 1'b1;
        #1 check("R2 rot_op", {24'h0, reg_rdata}, 32'h1F);

        // R3 latch/read mode 0
        preload(8'h40);
        set_reg(4'd4, 8'h02);
        cpu_read(8'h40, b);
        check("R3 plane2", {24'h0, b}, 32'h55);
        // R13 rdata holds across a write and register traffic
        cpu_write(8'h41, 8'h99, 4'hF);
        set_reg(4'd4, 8'h01);
        check("R13 hold", {24'h0, cpu_rdata}, 32'h55);
        // latch held: mode-1 copy to another address shows the 8'h40 data
        set_reg(4'd5, 8'h01);
        cpu_write(8'h42, 8'h00, 4'hF);
        read_planes(8'h42, w);
        check("R3 R13 latch", w, 32'hF055330F);

        // R4 colour compare
        set_reg(4'd2, 8'h0A);
        set_reg(4'd5, 8'h08);
        cpu_read(8'h40, b);
        check("R4 cmp A", {24'h0, b}, 32'h20);
        set_reg(4'd2, 8'h07);
        cpu_read(8'h40, b);
        check("R4 cmp 7", {24'h0, b}, 32'h01);

        // Table: R5 R6 R7 R8 R9 R10 R11 R12
        for (int i = 0; i < NVEC; i++) begin
            logic [ADDR_W-1:0] a;
            a = ADDR_W'(8'h80 + i);
            preload(a);
            cpu_read(a, b);
            set_reg(4'd5, {6'h0, VECS[i].mode});
            set_reg(4'd3, VECS[i].rot_op);
            set_reg(4'd1, {4'h0, VECS[i].fill_en});
            set_reg(4'd0, {4'h0, VECS[i].fill_val});
            set_reg(4'd8, VECS[i].mask);
            cpu_write(a, VECS[i].wdata, VECS[i].mm);
            read_planes(a, w);
            check($sformatf("R5/R6/R7/R8/R9/R10/R11/R12 vector %0d", i), w, VECS[i].expect_planes);
        end

        // R12 map mask zero leaves everything
        preload(8'h10);
        cpu_write(8'h10, 8'h00, 4'h0);
        read_planes(8'h10, w);
        check("R12 no planes", w, 32'hF055330F);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule